// File: doc/BRIEF.md
# Instruction Count Trigger Bank

This block holds a small bank of debug trigger slots and gives the instruction-count behaviour to those slots programmed for it. Each slot holds one 32-bit control word. The slot counts down instructions as they retire. When the count reaches zero, the slot asks the core for a breakpoint exception. A slot counts only the instructions retired at the privilege levels it enables. Under virtualization it uses a separate pair of enables for the guest levels.

Software writes a control word into a slot through a simple write port and reads any slot back through a combinational read port. The core supplies a retire strobe, its current privilege level and its virtualization flag. The bank returns two signals. The first is a breakpoint request in the same cycle as the retire that takes a count to zero. The second is a level that is high while some slot is still counting at the current privilege level. The core uses that level to force single-instruction stepping, so that each retire is seen on its own.

Top module: `icnt_trig_bank`

## Requirements
- R1: After reset every slot reads back as zero, and bkpt_o and icount_active_o are low.
- R2: A write stores wr_data_i unchanged into slot wr_slot_i. rd_data_o returns the stored word of slot rd_slot_i in the same cycle.
- R3: A slot whose type field (bits 31:28) is not 3 never changes on a retire and never contributes to either output.
- R4: A type-3 slot whose count field (bits 23:10) is zero never decrements and never fires.
- R5: With virt_i low, a slot is eligible when priv_i is 0 and bit 6 is set, when priv_i is 1 and bit 7 is set, or when priv_i is 3 and bit 9 is set. priv_i equal to 2 matches nothing.
- R6: With virt_i high, a slot is eligible only when priv_i is 0 and bit 25 is set, or when priv_i is 1 and bit 26 is set. Bits 6, 7 and 9 are then ignored.
- R7: On each cycle with retire_i high, every eligible type-3 slot with a nonzero count has its count reduced by exactly one. Several slots may do so in the same cycle. All other bits of the word are kept.
- R8: When a retire takes a count from 1 to 0 and the action field (bits 5:0) is 0, bkpt_o is high in that same cycle. The count then stays at zero.
- R9: A slot with a nonzero action field still counts down to zero but never raises bkpt_o.
- R10: icount_active_o is high exactly when some type-3 slot has a nonzero count and is eligible at the current priv_i and virt_i.
- R11: A write to a slot in the same cycle as a retire stores the written word. No decrement is applied to that slot, and it does not fire.
- R12: bkpt_o is the OR of the fire conditions of all slots in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| retire_i | input | 1 | One instruction retires this cycle |
| priv_i | input | 2 | Current privilege level (0 user, 1 supervisor, 3 machine) |
| virt_i | input | 1 | Virtualization active |
| wr_en_i | input | 1 | Write a slot control word |
| wr_slot_i | input | SLOT_W | Slot to write |
| wr_data_i | input | XLEN | Control word to write |
| rd_slot_i | input | SLOT_W | Slot to read |
| rd_data_o | output | XLEN | Control word of the slot being read |
| icount_active_o | output | 1 | Some slot is counting at the current level |
| bkpt_o | output | 1 | Breakpoint request, same cycle as the final retire |

## Verification
The assertions assume that priv_i, virt_i and retire_i describe one retiring instruction per cycle. They also assume that wr_slot_i names an existing slot whenever wr_en_i is high. The stimulus keeps the slot indices below the slot count. It changes the privilege inputs only between cycles, and it also uses priv_i equal to 2 as a level with no match. Corner cases are driven directly: a count that reaches zero under different actions, writes that collide with a retire, and several slots expiring on the same retire.

// File: rtl/icnt_pkg.sv
package icnt_pkg;
  localparam int unsigned TYPE_W   = 4;
  localparam logic [3:0]  TYPE_ICNT = 4'd3;
  localparam int unsigned CNT_LSB  = 10;
  localparam int unsigned CNT_W    = 14;
  localparam int unsigned ACT_LSB  = 0;
  localparam int unsigned ACT_W    = 6;
  localparam logic [5:0]  ACT_BKPT = 6'd0;
  localparam int unsigned EN_U     = 6;
  localparam int unsigned EN_S     = 7;
  localparam int unsigned EN_M     = 9;
  localparam int unsigned EN_VU    = 25;
  localparam int unsigned EN_VS    = 26;

  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_M = 2'd3
  } priv_e;
endpackage

// File: rtl/icnt_elig.sv
module icnt_elig
  import icnt_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] tdata1_i,
  input  logic [1:0]      priv_i,
  input  logic            virt_i,
  output logic            elig_o
);
  always_comb begin
    if (virt_i) begin
      elig_o = (priv_i == PRIV_U && tdata1_i[EN_VU]) ||
               (priv_i == PRIV_S && tdata1_i[EN_VS]);
    end else begin
      elig_o = (priv_i == PRIV_U && tdata1_i[EN_U]) ||
               (priv_i == PRIV_S && tdata1_i[EN_S]) ||
               (priv_i == PRIV_M && tdata1_i[EN_M]);
    end
  end
endmodule

// File: rtl/icnt_slot.sv
module icnt_slot
  import icnt_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic            retire_i,
  input  logic [1:0]      priv_i,
  input  logic            virt_i,
  output logic [XLEN-1:0] tdata1_o,
  output logic            armed_o,
  output logic            fire_o
);
  localparam int unsigned TYPE_LSB = XLEN - TYPE_W;

  logic [XLEN-1:0]  t1_q;
  logic [CNT_W-1:0] cnt;
  logic             is_icnt, elig, dec;

  assign cnt     = t1_q[CNT_LSB +: CNT_W];
  assign is_icnt = (t1_q[TYPE_LSB +: TYPE_W] == TYPE_ICNT);

  icnt_elig #(.XLEN(XLEN)) u_elig (
    .tdata1_i (t1_q),
    .priv_i   (priv_i),
    .virt_i   (virt_i),
    .elig_o   (elig)
  );

  assign armed_o = is_icnt && (cnt != '0) && elig;
  // CSR write wins over a same-cycle decrement
  assign dec     = retire_i && armed_o && !wr_i;
  assign fire_o  = dec && (cnt == CNT_W'(1)) && (t1_q[ACT_LSB +: ACT_W] == ACT_BKPT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t1_q <= '0;
    end else if (wr_i) begin
      t1_q <= wr_data_i;
    end else if (dec) begin
      t1_q[CNT_LSB +: CNT_W] <= cnt - CNT_W'(1);
    end
  end

  assign tdata1_o = t1_q;

  p_wr_store_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> tdata1_o == $past(wr_data_i));

  p_dec_one_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && armed_o && !wr_i) |=>
      tdata1_o[CNT_LSB +: CNT_W] == $past(tdata1_o[CNT_LSB +: CNT_W]) - CNT_W'(1));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !(retire_i && armed_o)) |=> $stable(tdata1_o));

  p_park_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && tdata1_o[CNT_LSB +: CNT_W] == '0) |=> tdata1_o[CNT_LSB +: CNT_W] == '0);

  p_fire_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> tdata1_o[CNT_LSB +: CNT_W] == '0);
endmodule

// File: rtl/icnt_trig_bank.sv
module icnt_trig_bank
  import icnt_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned NUM_SLOTS = 4,
  localparam int unsigned SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              retire_i,
  input  logic [1:0]        priv_i,
  input  logic              virt_i,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [XLEN-1:0]   wr_data_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic [XLEN-1:0]   rd_data_o,
  output logic              icount_active_o,
  output logic              bkpt_o
);
  logic [XLEN-1:0]      t1 [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] armed, fire;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    icnt_slot #(.XLEN(XLEN)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_en_i && (wr_slot_i == SLOT_W'(g))),
      .wr_data_i (wr_data_i),
      .retire_i  (retire_i),
      .priv_i    (priv_i),
      .virt_i    (virt_i),
      .tdata1_o  (t1[g]),
      .armed_o   (armed[g]),
      .fire_o    (fire[g])
    );
  end

  assign rd_data_o       = t1[rd_slot_i];
  assign icount_active_o = |armed;
  assign bkpt_o          = |fire;

  p_bkpt_needs_active_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bkpt_o |-> (retire_i && icount_active_o));

  p_wr_slot_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (int'(wr_slot_i) < NUM_SLOTS));
endmodule

// File: tb/tb_icnt_trig_bank.sv
module tb_icnt_trig_bank;
  localparam int XLEN = 32;
  localparam int NS   = 4;
  localparam int SW   = 2;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            retire_i = 1'b0, virt_i = 1'b0, wr_en_i = 1'b0;
  logic [1:0]      priv_i = 2'd3;
  logic [SW-1:0]   wr_slot_i = '0, rd_slot_i = '0;
  logic [XLEN-1:0] wr_data_i = '0;
  logic [XLEN-1:0] rd_data_o;
  logic            icount_active_o, bkpt_o;

  always #5 clk = ~clk;

  icnt_trig_bank #(.XLEN(XLEN), .NUM_SLOTS(NS)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .retire_i(retire_i), .priv_i(priv_i),
    .virt_i(virt_i), .wr_en_i(wr_en_i), .wr_slot_i(wr_slot_i),
    .wr_data_i(wr_data_i), .rd_slot_i(rd_slot_i), .rd_data_o(rd_data_o),
    .icount_active_o(icount_active_o), .bkpt_o(bkpt_o)
  );

  typedef struct {
    logic        bkpt;
    logic        act;
    logic [31:0] rd;
    string       req;
  } exp_t;

  exp_t        q[$];
  logic [31:0] m_t1 [NS];
  int          vectors = 0, fails = 0;
  bit          done = 0;

  // modes = {vs, vu, m, s, u}
  function automatic logic [31:0] mk(input logic [3:0] ty, input int cnt,
                                     input logic [4:0] modes, input logic [5:0] act);
    logic [31:0] w = '0;
    w[31:28] = ty;
    w[23:10] = 14'(cnt);
    w[6] = modes[0]; w[7] = modes[1]; w[9] = modes[2];
    w[25] = modes[3]; w[26] = modes[4];
    w[5:0] = act;
    return w;
  endfunction

  function automatic logic elig(input logic [31:0] w, input logic [1:0] p, input logic v);
    if (v) return (p == 2'd0 && w[25]) || (p == 2'd1 && w[26]);
    return (p == 2'd0 && w[6]) || (p == 2'd1 && w[7]) || (p == 2'd3 && w[9]);
  endfunction

  function automatic logic armed(input logic [31:0] w, input logic [1:0] p, input logic v);
    return w[31:28] == 4'd3 && w[23:10] != 14'd0 && elig(w, p, v);
  endfunction

  task automatic step(input logic ret, input logic [1:0] p, input logic v,
                      input logic we, input int ws, input logic [31:0] wd,
                      input int rs, input string req);
    exp_t e;
    @(negedge clk);
    retire_i = ret; priv_i = p; virt_i = v; wr_en_i = we;
    wr_slot_i = SW'(ws); wr_data_i = wd; rd_slot_i = SW'(rs);
    e.bkpt = 1'b0; e.act = 1'b0; e.rd = m_t1[rs]; e.req = req;
    for (int i = 0; i < NS; i++) begin
      logic a, hit;
      a = armed(m_t1[i], p, v);
      hit = we && ws == i;
      if (a) e.act = 1'b1;
      if (ret && a && !hit && m_t1[i][23:10] == 14'd1 && m_t1[i][5:0] == 6'd0)
        e.bkpt = 1'b1;
    end
    q.push_back(e);
    for (int i = 0; i < NS; i++) begin
      if (we && ws == i) m_t1[i] = wd;
      else if (ret && armed(m_t1[i], p, v)) m_t1[i][23:10] = m_t1[i][23:10] - 14'd1;
    end
  endtask

  // monitor: compares before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        vectors++;
        if (bkpt_o !== e.bkpt || icount_active_o !== e.act || rd_data_o !== e.rd) begin
          fails++;
          $display("FAIL %s: bkpt=%b exp %b, active=%b exp %b, rd=%h exp %h",
                   e.req, bkpt_o, e.bkpt, icount_active_o, e.act, rd_data_o, e.rd);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) m_t1[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    for (int i = 0; i < NS; i++) step(1, 2'd3, 0, 0, 0, 0, i, "R1");
    // R2 write and read back
    step(0, 2'd3, 0, 1, 0, mk(4'd3, 3, 5'b00100, 6'd0), 0, "R2");
    step(0, 2'd3, 0, 0, 0, 0, 0, "R2");
    step(0, 2'd0, 0, 0, 0, 0, 0, "R10");
    // R7 count down, R8 fire and park
    step(1, 2'd3, 0, 0, 0, 0, 0, "R7");
    step(1, 2'd3, 0, 0, 0, 0, 0, "R7");
    step(1, 2'd3, 0, 0, 0, 0, 0, "R8");
    step(1, 2'd3, 0, 0, 0, 0, 0, "R8");
    step(0, 2'd3, 0, 0, 0, 0, 0, "R4");
    // R3 other type ignored
    step(0, 2'd3, 0, 1, 1, mk(4'd2, 5, 5'b00100, 6'd0), 1, "R3");
    step(1, 2'd3, 0, 0, 0, 0, 1, "R3");
    step(1, 2'd3, 0, 0, 0, 0, 1, "R3");
    // R4 zero count inactive
    step(0, 2'd3, 0, 1, 1, mk(4'd3, 0, 5'b00100, 6'd0), 1, "R4");
    step(1, 2'd3, 0, 0, 0, 0, 1, "R4");
    // R5 user-only slot
    step(0, 2'd3, 0, 1, 2, mk(4'd3, 4, 5'b00001, 6'd0), 2, "R5");
    step(1, 2'd3, 0, 0, 0, 0, 2, "R5");
    step(1, 2'd1, 0, 0, 0, 0, 2, "R5");
    step(1, 2'd2, 0, 0, 0, 0, 2, "R5");
    step(1, 2'd0, 0, 0, 0, 0, 2, "R5");
    step(0, 2'd0, 0, 0, 0, 0, 2, "R10");
    // R6 virtualized levels
    step(0, 2'd0, 1, 1, 3, mk(4'd3, 2, 5'b10001, 6'd0), 3, "R6");
    step(1, 2'd0, 1, 0, 0, 0, 3, "R6");
    step(1, 2'd1, 1, 0, 0, 0, 3, "R6");
    step(1, 2'd3, 1, 0, 0, 0, 3, "R6");
    step(1, 2'd1, 0, 0, 0, 0, 3, "R6");
    step(1, 2'd1, 1, 0, 0, 0, 3, "R6");
    step(0, 2'd1, 1, 0, 0, 0, 3, "R6");
    // R9 nonzero action
    step(0, 2'd3, 0, 1, 0, mk(4'd3, 1, 5'b00100, 6'd1), 0, "R9");
    step(1, 2'd3, 0, 0, 0, 0, 0, "R9");
    step(0, 2'd3, 0, 0, 0, 0, 0, "R9");
    // R11 write beats decrement
    step(0, 2'd3, 0, 1, 0, mk(4'd3, 1, 5'b00100, 6'd0), 0, "R11");
    step(1, 2'd3, 0, 1, 0, mk(4'd3, 7, 5'b00100, 6'd0), 0, "R11");
    step(0, 2'd3, 0, 0, 0, 0, 0, "R11");
    // R12 several slots at once
    step(0, 2'd3, 0, 1, 0, mk(4'd3, 1, 5'b00100, 6'd0), 0, "R12");
    step(0, 2'd3, 0, 1, 1, mk(4'd3, 1, 5'b00100, 6'd0), 1, "R12");
    step(0, 2'd3, 0, 1, 2, mk(4'd3, 3, 5'b00100, 6'd0), 2, "R12");
    step(1, 2'd3, 0, 0, 0, 0, 0, "R12");
    step(0, 2'd3, 0, 0, 0, 0, 1, "R7");
    step(0, 2'd3, 0, 0, 0, 0, 2, "R7");
    step(1, 2'd3, 0, 0, 0, 0, 2, "R8");
    step(0, 2'd3, 0, 0, 0, 0, 2, "R8");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule